// File: doc/BRIEF.md
# CAN Receive Buffer Allocator

This block sits behind the acceptance filters of a CAN controller. Each frame that finishes on the bus is offered to it as a single transfer carrying the identifier, one match flag per acceptance filter, and a flag that marks the frame as the node's own transmission. A frame is taken when at least one filter matched. The block then looks for a free receive buffer among a small fixed set and records the result.

A buffer is free when software has not locked it and it holds no unread frame. If a free buffer exists, the block issues a one-cycle write strobe with the buffer index so that payload storage can capture the frame. It also marks the buffer as holding a frame, stores which filter matched, and pulses a receive event. If every buffer is busy, the block pulses an overrun event and keeps the dropped frame's identifier in a last-identifier register. Software frees a buffer by pulsing its clear line once the frame has been read.

Frames arrive over a valid/ready handshake. `msg_ready` is low while reset is held and from the first clock after reset it stays high. The block therefore never applies back-pressure and takes one frame per clock. A frame transfers on a clock where `msg_valid` and `msg_ready` are both high. The producer must hold `msg_id`, `msg_hit` and `msg_own` stable while `msg_valid` is high. Every result appears in registers one clock after the transfer.

Top module: `can_rx_alloc`

## Requirements
- R1: A transfer is taken only when at least one bit of `msg_hit` is set. A transfer with no filter hit causes no write strobe, no receive or overrun event, and no change to `last_id`.
- R2: The target is the lowest-indexed buffer (index 0 first, then 1, then 2) whose `buf_lock` bit and `buf_rdy` bit are both clear. Index 0 is the first buffer in the search order.
- R3: One clock after a taken transfer that has a target, `wr_en` and `rx_evt` are high for one clock and `wr_idx` holds the target index.
- R4: On a write, the target's field in `buf_acc` (bits `[i*FW +: FW]` for buffer i) takes the index of the lowest-numbered set bit of `msg_hit`. Bit 0 is filter 0.
- R5: `rx_irq` pulses together with `rx_evt` only when `rx_ie` was high in the transfer cycle.
- R6: One clock after a taken transfer that has no target, `ovr_evt` pulses and `last_id` holds that transfer's `msg_id`. `ovr_irq` pulses with `ovr_evt` only when `ovr_ie` was high in the transfer cycle.
- R7: `last_id` changes only on an overrun. Otherwise it holds its value.
- R8: A transfer with `msg_own` high is ignored unless `self_rx_en` is high. When `self_rx_en` is high, such a transfer is filtered and allocated like any other frame.
- R9: A write sets the target's `buf_rdy` bit. A pulse on `rdy_clr[i]` clears `buf_rdy[i]` at the next clock. A locked buffer is never chosen.
- R10: `msg_ready` is low while reset is held and high on every clock after reset.
- R11: After reset, all registered outputs are zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous reset, active low |
| msg_valid | input | 1 | Completed frame offered |
| msg_ready | output | 1 | Block accepts a frame |
| msg_id | input | ID_W | Frame identifier |
| msg_hit | input | NUM_FILT | Per-filter match flags |
| msg_own | input | 1 | Frame is the node's own transmission |
| self_rx_en | input | 1 | Allow own frames to be received |
| rx_ie | input | 1 | Receive interrupt enable |
| ovr_ie | input | 1 | Overrun interrupt enable |
| buf_lock | input | NUM_BUF | Software lock per buffer |
| rdy_clr | input | NUM_BUF | Pulse to clear a buffer's ready bit |
| wr_en | output | 1 | Write strobe to payload storage |
| wr_idx | output | BW | Target buffer index |
| buf_rdy | output | NUM_BUF | Buffer holds an unread frame |
| buf_acc | output | NUM_BUF*FW | Matching filter per buffer |
| rx_evt | output | 1 | Receive event pulse |
| rx_irq | output | 1 | Enabled receive interrupt pulse |
| ovr_evt | output | 1 | Overrun event pulse |
| ovr_irq | output | 1 | Enabled overrun interrupt pulse |
| last_id | output | ID_W | Identifier of the last dropped frame |

## Verification
The hardest state to reach is an overrun. Every buffer must be busy, some because they hold unread frames and others only because software locked them, and R2's order must still be visible as buffers free up in mixed order. The stimulus first fills buffers in sequence with a lock held on the middle one, so a lock forces a skip. It then sends a frame into the full set and releases buffers out of order. After that, a long pseudo-random phase toggles locks, clears, own-frame flags and enables, and a reference model predicts every output on every clock.

// File: rtl/can_rx_pkg.sv
package can_rx_pkg;
  typedef enum logic [1:0] {
    EV_NONE    = 2'd0,
    EV_STORE   = 2'd1,
    EV_OVERRUN = 2'd2
  } rx_event_e;
endpackage

// File: rtl/rx_first_set.sv
module rx_first_set #(
  parameter int N = 4,
  parameter int W = 2
) (
  input  logic [N-1:0] vec,
  output logic         any,
  output logic [W-1:0] idx
);
  always_comb begin
    idx = '0;
    for (int i = N - 1; i >= 0; i--) begin
      if (vec[i]) idx = W'(i);
    end
  end
  assign any = |vec;
endmodule

// File: rtl/rx_buf_slot.sv
module rx_buf_slot #(
  parameter int FW = 2
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          set,
  input  logic          clr,
  input  logic [FW-1:0] acc_in,
  output logic          rdy,
  output logic [FW-1:0] acc
);
  always_ff @(posedge clk) begin
    if (!rst_n) begin
      rdy <= 1'b0;
      acc <= '0;
    end else begin
      rdy <= (rdy & ~clr) | set;
      if (set) acc <= acc_in;
    end
  end
endmodule

// File: rtl/can_rx_alloc.sv
module can_rx_alloc
  import can_rx_pkg::*;
#(
  parameter int ID_W     = 29,
  parameter int NUM_FILT = 4,
  parameter int NUM_BUF  = 3,
  parameter int FW       = (NUM_FILT > 1) ? $clog2(NUM_FILT) : 1,
  parameter int BW       = (NUM_BUF > 1) ? $clog2(NUM_BUF) : 1
) (
  input  logic                   clk,
  input  logic                   rst_n,
  input  logic                   msg_valid,
  output logic                   msg_ready,
  input  logic [ID_W-1:0]        msg_id,
  input  logic [NUM_FILT-1:0]    msg_hit,
  input  logic                   msg_own,
  input  logic                   self_rx_en,
  input  logic                   rx_ie,
  input  logic                   ovr_ie,
  input  logic [NUM_BUF-1:0]     buf_lock,
  input  logic [NUM_BUF-1:0]     rdy_clr,
  output logic                   wr_en,
  output logic [BW-1:0]          wr_idx,
  output logic [NUM_BUF-1:0]     buf_rdy,
  output logic [NUM_BUF*FW-1:0]  buf_acc,
  output logic                   rx_evt,
  output logic                   rx_irq,
  output logic                   ovr_evt,
  output logic                   ovr_irq,
  output logic [ID_W-1:0]        last_id
);
  logic          hit_any;
  logic [FW-1:0] filt_idx;
  logic          free_any;
  logic [BW-1:0] free_idx;
  logic          take;
  rx_event_e     ev;

  rx_first_set #(.N(NUM_FILT), .W(FW)) u_filt (
    .vec (msg_hit),
    .any (hit_any),
    .idx (filt_idx)
  );

  rx_first_set #(.N(NUM_BUF), .W(BW)) u_free (
    .vec (~buf_lock & ~buf_rdy),
    .any (free_any),
    .idx (free_idx)
  );

  assign take = msg_valid && msg_ready && hit_any && (!msg_own || self_rx_en);

  always_comb begin
    if (!take)         ev = EV_NONE;
    else if (free_any) ev = EV_STORE;
    else               ev = EV_OVERRUN;
  end

  for (genvar g = 0; g < NUM_BUF; g++) begin : g_slot
    rx_buf_slot #(.FW(FW)) u_slot (
      .clk    (clk),
      .rst_n  (rst_n),
      .set    (ev == EV_STORE && free_idx == BW'(g)),
      .clr    (rdy_clr[g]),
      .acc_in (filt_idx),
      .rdy    (buf_rdy[g]),
      .acc    (buf_acc[g*FW +: FW])
    );
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      msg_ready <= 1'b0;
      wr_en     <= 1'b0;
      wr_idx    <= '0;
      rx_evt    <= 1'b0;
      rx_irq    <= 1'b0;
      ovr_evt   <= 1'b0;
      ovr_irq   <= 1'b0;
      last_id   <= '0;
    end else begin
      msg_ready <= 1'b1;
      wr_en     <= (ev == EV_STORE);
      rx_evt    <= (ev == EV_STORE);
      rx_irq    <= (ev == EV_STORE) && rx_ie;
      ovr_evt   <= (ev == EV_OVERRUN);
      ovr_irq   <= (ev == EV_OVERRUN) && ovr_ie;
      if (ev == EV_STORE)   wr_idx  <= free_idx;
      if (ev == EV_OVERRUN) last_id <= msg_id;
    end
  end
endmodule

// File: rtl/can_rx_alloc_chk.sv
module can_rx_alloc_chk #(
  parameter int ID_W     = 29,
  parameter int NUM_FILT = 4,
  parameter int NUM_BUF  = 3,
  parameter int FW       = 2,
  parameter int BW       = 2
) (
  input logic                  clk,
  input logic                  rst_n,
  input logic                  msg_valid,
  input logic                  msg_ready,
  input logic [ID_W-1:0]       msg_id,
  input logic [NUM_FILT-1:0]   msg_hit,
  input logic                  msg_own,
  input logic                  self_rx_en,
  input logic                  rx_ie,
  input logic                  ovr_ie,
  input logic [NUM_BUF-1:0]    buf_lock,
  input logic                  wr_en,
  input logic [BW-1:0]         wr_idx,
  input logic [NUM_BUF-1:0]    buf_rdy,
  input logic                  rx_evt,
  input logic                  rx_irq,
  input logic                  ovr_evt,
  input logic                  ovr_irq,
  input logic [ID_W-1:0]       last_id
);
  logic seen;
  logic taken;
  always_ff @(posedge clk) begin
    if (!rst_n) seen <= 1'b0;
    else        seen <= 1'b1;
  end
  assign taken = msg_valid && msg_ready && (msg_hit != '0) && (!msg_own || self_rx_en);

  // R1
  no_spurious_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !taken |=> (!wr_en && !ovr_evt));
  // R3
  one_outcome_chk: assert property (@(posedge clk) disable iff (!rst_n)
    taken |=> (wr_en != ovr_evt));
  // R2
  free_target_chk: assert property (@(posedge clk) disable iff (!rst_n)
    wr_en |-> (($past(buf_rdy) >> wr_idx) & 1'b1) == 1'b0 && (($past(buf_lock) >> wr_idx) & 1'b1) == 1'b0);
  // R9
  rdy_after_write_chk: assert property (@(posedge clk) disable iff (!rst_n)
    wr_en |-> ((buf_rdy >> wr_idx) & 1'b1) == 1'b1);
  // R5
  rx_irq_gate_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (taken && !rx_ie) |=> !rx_irq);
  // R6
  ovr_irq_pair_chk: assert property (@(posedge clk) disable iff (!rst_n)
    ovr_irq |-> ovr_evt);
  // R6
  ovr_id_chk: assert property (@(posedge clk) disable iff (!rst_n)
    ovr_evt |-> last_id == $past(msg_id));
  // R7
  last_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (seen && !ovr_evt) |-> $stable(last_id));
  // R3
  rx_pair_chk: assert property (@(posedge clk) disable iff (!rst_n)
    rx_evt == wr_en);
endmodule

bind can_rx_alloc can_rx_alloc_chk #(
  .ID_W(ID_W), .NUM_FILT(NUM_FILT), .NUM_BUF(NUM_BUF), .FW(FW), .BW(BW)
) u_chk (.*);

// File: tb/sim_can_rx_alloc.sv
module sim_can_rx_alloc;
  localparam int ID_W = 29, NF = 4, NB = 3, FW = 2, BW = 2;

  logic clk = 1'b0, rst_n = 1'b0;
  logic msg_valid = 0, msg_own = 0, self_rx_en = 0, rx_ie = 0, ovr_ie = 0;
  logic [ID_W-1:0] msg_id = '0;
  logic [NF-1:0] msg_hit = '0;
  logic [NB-1:0] buf_lock = '0, rdy_clr = '0;
  logic msg_ready, wr_en, rx_evt, rx_irq, ovr_evt, ovr_irq;
  logic [BW-1:0] wr_idx;
  logic [NB-1:0] buf_rdy;
  logic [NB*FW-1:0] buf_acc;
  logic [ID_W-1:0] last_id;

  always #5 clk = ~clk;

  can_rx_alloc u0 (.*);

  int checks = 0, fails = 0;
  bit started = 0, done = 0;

  // reference model state
  bit m_ready, m_wr, m_rxe, m_rxi, m_ove, m_ovi;
  int m_idx;
  bit m_rdy [NB];
  int m_acc [NB];
  logic [ID_W-1:0] m_last;
  int hit_n, tgt_n;
  bit tk;

  always @(posedge clk) begin
    if (!rst_n) begin
      m_ready = 0; m_wr = 0; m_rxe = 0; m_rxi = 0; m_ove = 0; m_ovi = 0;
      m_idx = 0; m_last = '0;
      for (int b = 0; b < NB; b++) begin m_rdy[b] = 0; m_acc[b] = 0; end
    end else begin
      tk = msg_valid && m_ready && (msg_hit != 0) && (!msg_own || self_rx_en);
      hit_n = -1;
      for (int f = NF - 1; f >= 0; f--) if (msg_hit[f]) hit_n = f;
      tgt_n = -1;
      for (int b = NB - 1; b >= 0; b--) if (!buf_lock[b] && !m_rdy[b]) tgt_n = b;
      for (int b = 0; b < NB; b++) if (rdy_clr[b]) m_rdy[b] = 0;
      m_wr = tk && tgt_n >= 0;
      m_rxe = m_wr; m_rxi = m_wr && rx_ie;
      m_ove = tk && tgt_n < 0; m_ovi = m_ove && ovr_ie;
      if (m_wr) begin m_idx = tgt_n; m_rdy[tgt_n] = 1; m_acc[tgt_n] = hit_n; end
      if (m_ove) m_last = msg_id;
      m_ready = 1;
      started = 1;
    end
  end

  task automatic chk(string tag, logic [63:0] act, logic [63:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s act=%0h exp=%0h at %0t", tag, act, exp, $time);
    end
  endtask

  always @(negedge clk) begin
    if (started && rst_n && !done) begin
      chk("R10 msg_ready", 64'(msg_ready), 64'(m_ready));
      chk("R1 R8 wr_en", 64'(wr_en), 64'(m_wr));
      if (m_wr) chk("R2 wr_idx", 64'(wr_idx), 64'(m_idx));
      chk("R3 rx_evt", 64'(rx_evt), 64'(m_rxe));
      chk("R5 rx_irq", 64'(rx_irq), 64'(m_rxi));
      chk("R6 ovr_evt", 64'(ovr_evt), 64'(m_ove));
      chk("R6 ovr_irq", 64'(ovr_irq), 64'(m_ovi));
      chk("R7 last_id", 64'(last_id), 64'(m_last));
      for (int b = 0; b < NB; b++) begin
        chk("R9 buf_rdy", 64'(buf_rdy[b]), 64'(m_rdy[b]));
        chk("R4 buf_acc", 64'(buf_acc[b*FW +: FW]), 64'(m_acc[b]));
      end
    end
  end

  task automatic send(logic [ID_W-1:0] id, logic [NF-1:0] hit, logic own);
    msg_valid = 1; msg_id = id; msg_hit = hit; msg_own = own;
    @(negedge clk);
    msg_valid = 0; msg_hit = '0; msg_own = 0;
  endtask

  task automatic idle(int n);
    for (int i = 0; i < n; i++) @(negedge clk);
  endtask

  initial begin
    #(200000 * 10);
    fails++;
    $display("FAIL watchdog expired act=running exp=finished");
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end

  initial begin
    idle(3);
    // R11: reset state
    chk("R11 reset outputs", {wr_en, rx_evt, rx_irq, ovr_evt, ovr_irq, msg_ready, buf_rdy, buf_acc},
        64'd0);
    chk("R11 reset last_id", 64'(last_id), 64'd0);
    rst_n = 1;
    idle(2);
    rx_ie = 1; ovr_ie = 1;
    send(29'h0000123, 4'b0000, 0);          // R1: no hit, ignored
    send(29'h0000456, 4'b0110, 0);          // R4: filter 1 into buffer 0
    buf_lock = 3'b010;
    send(29'h0000789, 4'b1000, 0);          // R2: lock skips buffer 1
    send(29'h1ABCDEF, 4'b0001, 0);          // R6: all busy -> overrun
    idle(3);                                // R7: hold
    send(29'h0000AAA, 4'b0011, 1);          // R8: own frame, ignored
    buf_lock = 3'b000;
    self_rx_en = 1;
    send(29'h0000BBB, 4'b0100, 1);          // R8: own frame received into buffer 1
    rdy_clr = 3'b100; @(negedge clk); rdy_clr = '0;   // R9
    rx_ie = 0;
    send(29'h0000CCC, 4'b1100, 0);          // R5: no irq, buffer 2
    ovr_ie = 0;
    send(29'h0000DDD, 4'b0001, 0);          // R6: overrun without irq
    rdy_clr = 3'b011; @(negedge clk); rdy_clr = '0;
    for (int c = 0; c < 2000; c++) begin
      msg_valid = ($urandom % 2) == 0;
      msg_id = ID_W'($urandom);
      msg_hit = ($urandom % 4 == 0) ? '0 : NF'($urandom);
      msg_own = ($urandom % 4) == 0;
      self_rx_en = ($urandom % 2) == 0;
      rx_ie = ($urandom % 2) == 0;
      ovr_ie = ($urandom % 2) == 0;
      if (c % 8 == 0) buf_lock = NB'($urandom % 8) & NB'($urandom % 8);
      rdy_clr = ($urandom % 3 == 0) ? NB'($urandom) : '0;
      @(negedge clk);
    end
    msg_valid = 0; rdy_clr = '0;
    idle(3);
    done = 1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end
endmodule